// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the even parity bit of a 32-bit multiplexed address/data bus. The parity also covers the four command/byte-enable lines. The surrounding bus engine reports each phase through qualifier inputs: address phase, data phase, transfer direction, and whether this agent is the initiator or the target. From these the block decides whether it drives the parity line on the next clock.

When the agent is the target of a write, the block takes the parity that arrives one clock after each data phase. It compares that bit with the parity it computed from the captured bus values. On a mismatch it pulls its active-low error line for one clock and sets a sticky error flag. It can also pulse one of two interrupt requests, and the same requests can fire when another agent reports a parity error on the bus.

Top module: `pci_parity_unit`

## Requirements
- R1: The driven parity bit makes the count of ones across the 32 AD bits, the 4 C/BE bits and the parity bit even, using all 36 bits whatever the byte-enable values.
- R2: `par_o` and `par_oe_o` change on the clock edge that samples the phase, so both are valid for exactly the one clock that follows that phase.
- R3: During an address phase, `par_oe_o` is asserted on the next clock only when `is_initiator_i` is 1.
- R4: During a data phase, `par_oe_o` is asserted on the next clock when the agent is initiator with `is_write_i`=1 or target with `is_write_i`=0; it stays 0 for initiator reads and target writes.
- R5: Incoming parity `par_i` is checked only one clock after a data phase in which the agent is the target (`is_initiator_i`=0) of a write (`is_write_i`=1). No other phase kind can cause an error.
- R6: On a mismatch, `perr_n_o` is 0 and `perr_oe_o` is 1 for exactly the clock after `par_i` was sampled. Otherwise `perr_n_o`=1 and `perr_oe_o`=0.
- R7: `err_flag_o` is set by the block's own detection, on the same edge that asserts `perr_n_o`. It stays set until an edge on which `status_clr_i`=1 and no new detection occurs, because detection wins over clear. An external error report does not set it.
- R8: When `irq_en_i`=1, an own detection or a low `ext_perr_n_i` sampled on an edge produces a one-clock pulse on `irq_a_o` if `irq_sel_i`=0, or on `irq_b_o` if `irq_sel_i`=1. When `irq_en_i`=0, neither output pulses.
- R9: While `rst_n` is 0, `par_oe_o`=0, `perr_oe_o`=0, `perr_n_o`=1, `err_flag_o`=0 and both interrupt outputs are 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value |
| cbe_i | input | 4 | Command/byte-enable bus value |
| addr_phase_i | input | 1 | Current clock is an address phase |
| data_phase_i | input | 1 | Current clock completes a data phase |
| is_write_i | input | 1 | Transaction direction, 1 = write |
| is_initiator_i | input | 1 | 1 = this agent initiated the transaction, 0 = target |
| par_i | input | 1 | Parity received from the bus |
| ext_perr_n_i | input | 1 | Active-low parity error reported by another agent |
| status_clr_i | input | 1 | Write-one-to-clear for the error flag |
| irq_en_i | input | 1 | Interrupt enable |
| irq_sel_i | input | 1 | Interrupt output select, 0 = A, 1 = B |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Drive enable for the parity line |
| perr_n_o | output | 1 | Active-low parity error output |
| perr_oe_o | output | 1 | Drive enable for the error line |
| err_flag_o | output | 1 | Sticky detected-parity-error flag |
| irq_a_o | output | 1 | Interrupt request A pulse |
| irq_b_o | output | 1 | Interrupt request B pulse |

## Verification
The generated parity and its enable are due one edge after the phase inputs are applied. The error line, the flag and the interrupt from a bad target-write parity are due one edge after `par_i` is presented, which is two edges after the phase. An external report raises its interrupt one edge after it is seen. The bench drives each stimulus at a falling edge and waits the exact number of rising edges before it samples at the next falling edge. It then checks the following falling edge as well, to confirm that the error and interrupt pulses last only one clock.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [DATA_W/8-1:0] cbe_i,
  input  logic              addr_phase_i,
  input  logic              data_phase_i,
  input  logic              is_write_i,
  input  logic              is_initiator_i,
  input  logic              par_i,
  input  logic              ext_perr_n_i,
  input  logic              status_clr_i,
  input  logic              irq_en_i,
  input  logic              irq_sel_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              perr_n_o,
  output logic              perr_oe_o,
  output logic              err_flag_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] lane_par;
  logic calc_par, drive_addr, drive_data, chk_now;
  logic par_q, par_oe_q, chk_q, exp_q;
  logic perr_n_q, perr_oe_q, flag_q, irq_a_q, irq_b_q;
  logic mismatch, irq_evt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^{ad_i[g*8 +: 8], cbe_i[g]};
  end

  assign calc_par   = ^lane_par;
  assign drive_addr = addr_phase_i & is_initiator_i;
  assign drive_data = data_phase_i & (is_initiator_i ? is_write_i : ~is_write_i);
  assign chk_now    = data_phase_i & ~is_initiator_i & is_write_i;
  assign mismatch   = chk_q & (par_i ^ exp_q);
  assign irq_evt    = irq_en_i & (mismatch | ~ext_perr_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q     <= 1'b0;
      par_oe_q  <= 1'b0;
      chk_q     <= 1'b0;
      exp_q     <= 1'b0;
      perr_n_q  <= 1'b1;
      perr_oe_q <= 1'b0;
      flag_q    <= 1'b0;
      irq_a_q   <= 1'b0;
      irq_b_q   <= 1'b0;
    end else begin
      par_q     <= calc_par;
      par_oe_q  <= drive_addr | drive_data;
      chk_q     <= chk_now;
      exp_q     <= calc_par;
      perr_n_q  <= ~mismatch;
      perr_oe_q <= mismatch;
      flag_q    <= mismatch | (flag_q & ~status_clr_i);
      irq_a_q   <= irq_evt & ~irq_sel_i;
      irq_b_q   <= irq_evt & irq_sel_i;
    end
  end

  assign par_o      = par_q;
  assign par_oe_o   = par_oe_q;
  assign perr_n_o   = perr_n_q;
  assign perr_oe_o  = perr_oe_q;
  assign err_flag_o = flag_q;
  assign irq_a_o    = irq_a_q;
  assign irq_b_o    = irq_b_q;
endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ad_i,
  input logic [DATA_W/8-1:0] cbe_i,
  input logic              addr_phase_i,
  input logic              data_phase_i,
  input logic              is_write_i,
  input logic              is_initiator_i,
  input logic              status_clr_i,
  input logic              irq_en_i,
  input logic              par_o,
  input logic              par_oe_o,
  input logic              perr_n_o,
  input logic              perr_oe_o,
  input logic              err_flag_o,
  input logic              irq_a_o,
  input logic              irq_b_o
);
  logic seen1, seen2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n || !seen1)
    par_oe_o |-> (^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0); // R1
  AST_PAR_OE_RULE: assert property (@(posedge clk) disable iff (!rst_n || !seen1)
    par_oe_o == $past((addr_phase_i && is_initiator_i) ||
                      (data_phase_i && (is_initiator_i == is_write_i)))); // R2
  AST_PERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    perr_oe_o == !perr_n_o); // R6
  AST_PERR_TGT_WR: assert property (@(posedge clk) disable iff (!rst_n || !seen2)
    !perr_n_o |-> $past(data_phase_i && !is_initiator_i && is_write_i, 2)); // R5
  AST_FLAG_ON_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> err_flag_o); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !seen1)
    ($past(err_flag_o) && !$past(status_clr_i)) |-> err_flag_o); // R7
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_a_o, irq_b_o})); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n || !seen1)
    (irq_a_o || irq_b_o) |-> $past(irq_en_i)); // R8
endmodule

bind pci_parity_unit pci_parity_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
  .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i),
  .is_write_i(is_write_i), .is_initiator_i(is_initiator_i),
  .status_clr_i(status_clr_i), .irq_en_i(irq_en_i),
  .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o),
  .perr_oe_o(perr_oe_o), .err_flag_o(err_flag_o),
  .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
);

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0] cbe_i = '0;
  logic addr_phase_i = 0, data_phase_i = 0, is_write_i = 0, is_initiator_i = 0;
  logic par_i = 0, ext_perr_n_i = 1, status_clr_i = 0, irq_en_i = 0, irq_sel_i = 0;
  logic par_o, par_oe_o, perr_n_o, perr_oe_o, err_flag_o, irq_a_o, irq_b_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0, flag_m = 0;

  always #2.5 clk = ~clk;

  pci_parity_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i),
    .is_write_i(is_write_i), .is_initiator_i(is_initiator_i),
    .par_i(par_i), .ext_perr_n_i(ext_perr_n_i), .status_clr_i(status_clr_i),
    .irq_en_i(irq_en_i), .irq_sel_i(irq_sel_i),
    .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o),
    .perr_oe_o(perr_oe_o), .err_flag_o(err_flag_o),
    .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic ones_odd(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    for (int i = 0; i < 4; i++) n += int'(c[i]);
    return logic'(n % 2);
  endfunction

  task automatic run_phase(input logic [31:0] a, input logic [3:0] c, input bit dp,
                           input bit init, input bit wr, input bit bad,
                           input bit en, input bit sel);
    logic p = ones_odd(a, c);
    bit drv = dp ? ((init && wr) || (!init && !wr)) : init;
    bit err = dp && !init && wr && bad;
    @(negedge clk);
    ad_i = a; cbe_i = c; addr_phase_i = !dp; data_phase_i = dp;
    is_initiator_i = init; is_write_i = wr; irq_en_i = en; irq_sel_i = sel; par_i = 0;
    @(negedge clk);
    chk(dp ? "R4" : "R3", par_oe_o, drv);
    if (drv) chk("R1", par_o, p);
    addr_phase_i = 0; data_phase_i = 0; ad_i = ~a; par_i = p ^ bad;
    @(negedge clk);
    chk("R2", par_oe_o, 1'b0);
    chk("R5", perr_n_o, !err);
    chk("R6", perr_oe_o, err);
    flag_m = flag_m | err;
    chk("R7", err_flag_o, flag_m);
    chk("R8", irq_a_o, err && en && !sel);
    chk("R8", irq_b_o, err && en && sel);
    @(negedge clk);
    chk("R6", perr_n_o, 1'b1);
    chk("R8", irq_a_o | irq_b_o, 1'b0);
  endtask

  initial begin
    logic [31:0] pats [8];
    pats[0] = 32'h0; pats[1] = 32'hffff_ffff; pats[2] = 32'h8000_0001;
    pats[3] = 32'ha5a5_a5a5; pats[4] = 32'h1234_5678; pats[5] = 32'h0000_0100;
    pats[6] = 32'hdead_beef; pats[7] = 32'h7fff_fffe;
    addr_phase_i = 1; is_initiator_i = 1; data_phase_i = 1; ext_perr_n_i = 0; irq_en_i = 1;
    repeat (3) @(negedge clk);
    chk("R9", par_oe_o, 0); chk("R9", perr_oe_o, 0); chk("R9", perr_n_o, 1);
    chk("R9", err_flag_o, 0); chk("R9", irq_a_o | irq_b_o, 0);
    addr_phase_i = 0; data_phase_i = 0; is_initiator_i = 0; ext_perr_n_i = 1; irq_en_i = 0;
    @(negedge clk); rst_n = 1;

    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 16; k++)
        run_phase(pats[p] ^ 32'(k * 32'h0101_0101), 4'(k + p), k[3], k[2], k[1], k[0],
                  p[0] | k[3], p[1]);

    // R7: clear, and detection beats a simultaneous clear
    @(negedge clk); status_clr_i = 1;
    @(negedge clk); status_clr_i = 0; flag_m = 0;
    chk("R7", err_flag_o, 1'b0);
    @(negedge clk);
    ad_i = 32'h3; cbe_i = 4'h0; data_phase_i = 1; is_write_i = 1; is_initiator_i = 0;
    @(negedge clk);
    data_phase_i = 0; par_i = 1'b1; status_clr_i = 1;
    @(negedge clk); status_clr_i = 0;
    chk("R7", err_flag_o, 1'b1);
    chk("R6", perr_n_o, 1'b0);

    // R8 and R7: external report pulses the chosen interrupt, flag untouched
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); status_clr_i = 1; irq_en_i = s[0]; irq_sel_i = s[1]; ext_perr_n_i = 0;
      @(negedge clk); ext_perr_n_i = 1; status_clr_i = 0;
      chk("R8", irq_a_o, s[0] && !s[1]);
      chk("R8", irq_b_o, s[0] && s[1]);
      chk("R7", err_flag_o, 1'b0);
      @(negedge clk);
      chk("R8", irq_a_o | irq_b_o, 1'b0);
    end

    // R9: mid-run reset with a pending error
    @(negedge clk); ad_i = 32'h1; cbe_i = 0; data_phase_i = 1; is_write_i = 1; is_initiator_i = 0;
    irq_en_i = 1;
    @(negedge clk); data_phase_i = 0; par_i = 0;
    @(negedge clk); rst_n = 0; #1;
    chk("R9", perr_n_o, 1'b1); chk("R9", err_flag_o, 1'b0); chk("R9", irq_a_o, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule